// File: doc/BRIEF.md
# Keyboard and Beeper I/O Port

This block is a one-byte I/O port on a small computer's peripheral bus. Any even I/O address selects it, although software is expected to use low byte 0xFE. A write stores a three-bit border colour and two sound-control bits. The first sound bit drives the tape-output line (MIC). The second drives the loudspeaker and the EAR line. All three values drive the block's outputs from the next clock.

A read returns a combinational byte. Its low five bits come from an 8-row by 5-column key matrix. The upper address byte picks the rows, one active-low line per row, and several rows may be picked at once. Bit 6 reports the sound line as it would be read back. That value depends on the stored sound bits, in a way set by the board-revision parameter, and on a digital ear input. Bits 5 and 7 always read as one.

Top module: `kbd_beep_port`

## Requirements
- R1: The port is selected only when io_addr[0] is 0. A write to an odd address leaves the stored state unchanged. A read from an odd address, or any cycle without io_rd, returns 8'hFF.
- R2: A selected write stores io_wdata[2:0] as the border colour, which appears on `border` from the clock edge that takes the write.
- R3: mic_on is the inverse of the stored io_wdata[3], and spk_on equals the stored io_wdata[4]. io_wdata[7:5] has no effect on any output.
- R4: While rst_n is low, the stored byte is cleared: border = 0, spk_on = 0 and mic_on = 1.
- R5: On a selected read, io_rdata[c] (c = 0..4) is 0 if key_down[r*5+c] is 1 for some row r whose select line io_addr[8+r] is 0. A row whose select line is 1 has no effect.
- R6: When several row lines are low, each of io_rdata[4:0] is the AND of the active-low data of all selected rows. With all rows deselected, io_rdata[4:0] reads 5'h1F.
- R7: On a selected read, io_rdata[7] and io_rdata[5] are always 1.
- R8: With BOARD_REV = 3, io_rdata[6] on a selected read equals the stored bit 4 OR ear_in.
- R9: With BOARD_REV = 2, io_rdata[6] on a selected read equals the stored bit 4 OR the stored bit 3 OR ear_in.
- R10: A read in the same cycle as a selected write returns bit 6 from the state before that write. The new state is visible on the next cycle.
- R11: ear_in = 1 forces io_rdata[6] to 1 on a selected read, whatever the stored bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O address; bit 0 selects the port, bits 15:8 select the key rows (active low) |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 8'hFF when the port is not being read |
| key_down | input | 40 | Pressed keys, active high, index row*5+column |
| ear_in | input | 1 | Digital level of the external sound input |
| border | output | 3 | Stored border colour |
| mic_on | output | 1 | Tape-output line active |
| spk_on | output | 1 | Speaker and EAR line active |

## Verification
A write and a read can hit the port in the same cycle. The stored sound bits then change while bit 6 of the read depends on them. The bench raises io_wr and io_rd together with data that flips bit 4, or bit 3 on the revision-2 copy. The byte returned in that cycle must follow the old state, and the read in the next cycle must follow the new one. A key-matrix read with a write to an odd address in the same cycle shows that the ignored write leaves both the read byte and the outputs unchanged.

// File: rtl/kbp_pkg.sv
// Shared constants and the stored-state layout for the keyboard/beeper port.
// Assumes the key matrix fits under the upper address byte (rows <= 8).
package kbp_pkg;
    localparam int KBP_ROWS   = 8;
    localparam int KBP_COLS   = 5;
    localparam int KBP_ADDR_W = 16;
    localparam int KBP_DATA_W = 8;
    localparam int KBP_ROW_LSB = 8;

    // Raw copy of the written bits 4:0; bit 4 is sound, bit 3 tape (low = on)
    typedef struct packed {
        logic       snd;
        logic       tape_n;
        logic [2:0] colour;
    } kbp_state_t;
endpackage

// File: rtl/kbp_select.sv
// Port select: the port answers on every even I/O address.
// Assumes bit 0 is the only address bit that takes part in decoding.
module kbp_select #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic unused_addr_bits;

    // Select whenever the low address bit is clear
    assign hit = ~addr[0];
    // Remaining bits carry no decode meaning here
    assign unused_addr_bits = ^addr[ADDR_W-1:1];
endmodule

// File: rtl/kbp_out_latch.sv
// Output latch: holds border colour and sound bits taken from a port write.
// Assumes a single-cycle write strobe; clears to zero on synchronous reset.
module kbp_out_latch
    import kbp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output kbp_state_t        state_q
);
    logic unused_wdata_hi;

    // Capture the low five data bits on a selected write
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (wr_en)
            state_q <= kbp_state_t'(wdata[4:0]);
    end

    // Upper data bits have no function on this port
    assign unused_wdata_hi = ^wdata[DATA_W-1:5];
endmodule

// File: rtl/kbp_key_merge.sv
// Key matrix merge: turns the pressed-key vector into active-low column data.
// A column reads low if a pressed key in that column sits in a selected row,
// which gives the AND of the active-low rows. Row selects are active low.
module kbp_key_merge #(
    parameter int ROWS = 8,
    parameter int COLS = 5,
    localparam int KEYS = ROWS * COLS
) (
    input  logic [ROWS-1:0] row_sel_n,
    input  logic [KEYS-1:0] key_down,
    output logic [COLS-1:0] col_n
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic hit_any;

        // OR the pressed state of this column over all selected rows
        always_comb begin
            hit_any = 1'b0;
            for (int r = 0; r < ROWS; r++)
                hit_any = hit_any | (key_down[r*COLS + c] & ~row_sel_n[r]);
        end

        assign col_n[c] = ~hit_any;
    end
endmodule

// File: rtl/kbp_audio_fb.sv
// Audio read-back: gives the level of the shared sound line as seen by a read.
// The revision picks which stored bits pull the line above threshold;
// the external input is a clean digital level ORed in.
module kbp_audio_fb
    import kbp_pkg::*;
#(
    parameter int REV = 3
) (
    input  kbp_state_t state_q,
    input  logic       ear_in,
    output logic       level
);
    logic driven;

    if (REV == 2) begin : g_rev2
        // Either sound bit alone keeps the line high
        assign driven = state_q.snd | state_q.tape_n;
    end else begin : g_rev3
        // Only the speaker bit keeps the line high
        assign driven = state_q.snd;
        logic unused_tape;
        assign unused_tape = state_q.tape_n;
    end

    // Combine driven level with the external input
    assign level = driven | ear_in;
endmodule

// File: rtl/kbd_beep_port.sv
// Keyboard and beeper I/O port (top).
// Writes store border colour and sound bits; reads return key columns,
// audio read-back and constant ones. Reads are combinational in the
// read cycle; when not read the data bus idles at all ones.
module kbd_beep_port
    import kbp_pkg::*;
#(
    parameter int BOARD_REV = 3,
    parameter int ROWS      = KBP_ROWS,
    parameter int COLS      = KBP_COLS,
    localparam int KEYS     = ROWS * COLS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [KBP_ADDR_W-1:0] io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [KBP_DATA_W-1:0] io_wdata,
    output logic [KBP_DATA_W-1:0] io_rdata,
    input  logic [KEYS-1:0]       key_down,
    input  logic                  ear_in,
    output logic [2:0]            border,
    output logic                  mic_on,
    output logic                  spk_on
);
    logic            hit;
    kbp_state_t      state_q;
    logic [COLS-1:0] col_n;
    logic            snd_level;

    kbp_select #(.ADDR_W(KBP_ADDR_W)) u_sel (
        .addr (io_addr),
        .hit  (hit)
    );

    kbp_out_latch #(.DATA_W(KBP_DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr & hit),
        .wdata   (io_wdata),
        .state_q (state_q)
    );

    kbp_key_merge #(.ROWS(ROWS), .COLS(COLS)) u_keys (
        .row_sel_n (io_addr[KBP_ROW_LSB +: ROWS]),
        .key_down  (key_down),
        .col_n     (col_n)
    );

    kbp_audio_fb #(.REV(BOARD_REV)) u_audio (
        .state_q (state_q),
        .ear_in  (ear_in),
        .level   (snd_level)
    );

    // Assemble the read byte, idle bus outside a selected read
    always_comb begin
        io_rdata = '1;
        if (io_rd && hit) begin
            io_rdata[COLS-1:0] = col_n;
            io_rdata[6]        = snd_level;
        end
    end

    // Drive the stored state onto the outputs
    assign border = state_q.colour;
    assign mic_on = ~state_q.tape_n;
    assign spk_on = state_q.snd;
endmodule

// File: rtl/kbp_port_chk.sv
// Checker for kbd_beep_port: port-level properties, attached by bind.
module kbp_port_chk #(
    parameter int REV = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        ear_in,
    input logic [2:0]  border,
    input logic        mic_on,
    input logic        spk_on
);
    logic rd_hit;
    assign rd_hit = io_rd & ~io_addr[0];

    // R2
    border_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !io_addr[0] |=> border == $past(io_wdata[2:0]));

    // R3
    sound_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !io_addr[0] |=> (spk_on == $past(io_wdata[4])) && (mic_on == !$past(io_wdata[3])));

    // R1
    odd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && !io_addr[0]) |=> $stable(border) && $stable(mic_on) && $stable(spk_on));

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> io_rdata == 8'hFF);

    // R7
    const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> io_rdata[7] && io_rdata[5]);

    // R6
    no_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && io_addr[15:8] == 8'hFF |-> io_rdata[4:0] == 5'h1F);

    // R11
    ear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && ear_in |-> io_rdata[6]);

    if (REV == 2) begin : g_r2
        // R9
        rev2_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit && !ear_in && !spk_on && mic_on |-> !io_rdata[6]);
    end else begin : g_r3
        // R8
        rev3_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit && !ear_in && !spk_on |-> !io_rdata[6]);
    end

    // R8
    spk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && spk_on |-> io_rdata[6]);
endmodule

bind kbd_beep_port kbp_port_chk #(.REV(BOARD_REV)) u_port_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .ear_in   (ear_in),
    .border   (border),
    .mic_on   (mic_on),
    .spk_on   (spk_on)
);

// File: tb/test_kbd_beep_port.sv
// Scoreboard bench: the driver computes expected items from a bench model
// and queues them, the monitor pops each one and compares it with the ports.
module test_kbd_beep_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'hFFFF;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [39:0] key_down = '0;
    logic        ear_in = 1'b0;
    logic [7:0]  rd3, rd2;
    logic [2:0]  bd3, bd2;
    logic        mic3, mic2, spk3, spk2;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [7:0] rd3;
        logic [7:0] rd2;
        logic [2:0] border;
        logic       mic;
        logic       spk;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;
    logic [4:0] model_st = 5'd0;

    always #4 clk = ~clk;

    kbd_beep_port #(.BOARD_REV(3)) i_kbd_beep_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rd3), .key_down(key_down), .ear_in(ear_in),
        .border(bd3), .mic_on(mic3), .spk_on(spk3)
    );

    kbd_beep_port #(.BOARD_REV(2)) i_kbd_beep_port_rev2 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rd2), .key_down(key_down), .ear_in(ear_in),
        .border(bd2), .mic_on(mic2), .spk_on(spk2)
    );

    function automatic logic [7:0] model_rd(int rev, logic [4:0] st, logic [15:0] a,
                                            logic rd, logic [39:0] k, logic e);
        logic [4:0] cols;
        logic       lvl;
        if (!rd || a[0]) return 8'hFF;
        cols = 5'h1F;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 5; c++)
                if (!a[8+r] && k[r*5+c]) cols[c] = 1'b0;
        lvl = (rev == 3) ? st[4] : (st[4] | st[3]);
        return {1'b1, lvl | e, 1'b1, cols};
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one bus cycle at the falling edge and queue its expectation
    task automatic step(logic [15:0] a, logic wr, logic rd, logic [7:0] wd,
                        logic [39:0] k, logic e, string tag);
        item_t it;
        @(negedge clk);
        io_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd; key_down = k; ear_in = e;
        #1;
        it.rd3 = model_rd(3, model_st, a, rd, k, e);
        it.rd2 = model_rd(2, model_st, a, rd, k, e);
        it.border = model_st[2:0];
        it.mic = ~model_st[3];
        it.spk = model_st[4];
        it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #1;
        if (wr && !a[0]) model_st = wd[4:0];
    endtask

    // Monitor: compare ports against the oldest queued item
    initial begin
        forever begin
            item_t it;
            @(sample_ev);
            it = exp_q.pop_front();
            check(it.tag, "rdata rev3", rd3, it.rd3);
            check(it.tag, "rdata rev2", rd2, it.rd2);
            check(it.tag, "border", {5'd0, bd3}, {5'd0, it.border});
            check(it.tag, "mic/spk", {6'd0, mic3, spk3}, {6'd0, it.mic, it.spk});
            check(it.tag, "rev2 state", {3'd0, mic2, spk2, bd2}, {3'd0, it.mic, it.spk, it.border});
        end
    end

    // Watchdog
    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state, R7 constant bits, R8/R9 low line after reset
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R4");
        // R2/R3 write both sound bits high
        step(16'h00FE, 1, 0, 8'h1B, '0, 0, "R2");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R3");
        // R3 upper bits ignored, both sound bits low
        step(16'h00FE, 1, 0, 8'hE7, '0, 0, "R3_hi");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R8_low");
        // R8/R9 tape bit only: revisions differ
        step(16'h12FE, 1, 0, 8'h0D, '0, 0, "R9");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R9_diff");
        // R11 ear input forces one
        step(16'hFFFE, 0, 1, 8'h00, '0, 1, "R11");
        // R1 odd-address write ignored, odd read idles
        step(16'h00FF, 1, 0, 8'h12, '0, 0, "R1_wr");
        step(16'hFFFF, 0, 1, 8'h00, 40'hFF_FFFF_FFFF, 0, "R1_rd");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R1_after");
        // R5 one key, selected row and unselected row
        step(16'hFEFE, 0, 1, 8'h00, 40'h1, 0, "R5_sel");
        step(16'h7FFE, 0, 1, 8'h00, 40'h1, 0, "R5_unsel");
        step(16'h7FFE, 0, 1, 8'h00, 40'h1 << 37, 0, "R5_row7");
        // R6 two rows combined, all rows, none
        step(16'h7EFE, 0, 1, 8'h00, (40'h1 << 1) | (40'h1 << 38), 0, "R6_two");
        step(16'h00FE, 0, 1, 8'h00, (40'h1 << 14) | (40'h1 << 20), 0, "R6_all");
        step(16'hFFFE, 0, 1, 8'h00, 40'hFF_FFFF_FFFF, 0, "R6_none");
        // R10 read and write in the same cycle, then the read after
        step(16'hFFFE, 1, 1, 8'h10, '0, 0, "R10_same");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R10_next");
        step(16'hFFFE, 1, 1, 8'h00, '0, 0, "R10_fall");
        step(16'hFFFE, 1, 1, 8'h08, '0, 0, "R10_tape");
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R10_tape_next");
        // R1 odd write with simultaneous key read
        step(16'hFDFF, 1, 1, 8'h1F, 40'h3E0, 0, "R1_both");
        step(16'hFDFE, 0, 1, 8'h00, 40'h3E0, 0, "R5_row1");
        // Mixed pattern sweep (R5 R6 R8 R9 R11)
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 60; i++) begin
            logic [39:0] k;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            k = {lfsr[7:0], lfsr} & {lfsr[15:8], lfsr[23:0], lfsr[31:24]};
            step({lfsr[23:9], lfsr[3] & lfsr[4]}, lfsr[5], lfsr[6] | lfsr[7],
                 lfsr[31:24], k, lfsr[8] & lfsr[9], "R6_sweep");
        end
        // R4 reset clears the latch again
        step(16'h00FE, 1, 0, 8'h1F, '0, 0, "R4_pre");
        @(negedge clk);
        rst_n = 1'b0;
        io_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_st = 5'd0;
        step(16'hFFFE, 0, 1, 8'h00, '0, 0, "R4_again");
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule